// File: doc/BRIEF.md
# Heartbeat Failure Monitor

This block supervises a group of compute nodes. Each node raises its own heartbeat count, and the count reaches the monitor as one input word per node. A free-running interval timer tells the monitor when to sample every count. A node whose count has not moved for a programmed number of consecutive samples is marked failed. The failure stays latched until it is cleared, and it is announced once as an event.

The event is a one-cycle pulse. It carries the failed node's index and a destination vector naming every node that subscribed to that node's failures. Each subscriber has a row of mask bits, one bit per watched node. A node is never told about its own failure. When several nodes fail on the same sample, their events leave one per cycle in ascending index order.

Two state machines set the timing. The serializer has two states. In `EV_QUIET` no event is on the outputs. In `EV_SEND` an event is on the outputs for this cycle. The transition "grant" goes from either state to `EV_SEND` whenever a pending failure remains that is not being cleared. The transition "drain" goes from either state to `EV_QUIET` when nothing is pending. Each node tracker has two conditions, watching and failed. It moves from watching to failed on a "declare" at a sample edge. It moves from failed back to watching on a "clear".

Top module: `hb_failure_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `fail_status` is all zero and `evt_valid` is low.
- R2: A sample is taken on the last cycle of every INTERVAL-cycle window, counted from reset release. Any difference between a node's count and its previous sample is progress, and this includes a wrap from all-ones to zero. Progress sets that node's miss count to zero. The previous sample is zero after reset.
- R3: A node is declared failed on the sample at which its count of consecutive unchanged samples reaches `miss_limit`. Its `fail_status` bit rises at that clock edge. A `miss_limit` of 0 acts as 1.
- R4: A `fail_status` bit stays set until the matching `clear_fail` bit is high at a clock edge. A clear zeroes the bit and the miss count, and it wins over a failure on the same edge. It also discards an event for that node that has not yet been sent.
- R5: A failed node produces no further event and does not count misses until it is cleared.
- R6: An event appears on the cycle after its failure edge if nothing earlier is queued. During that one cycle, `evt_valid` is high and `evt_node` holds the failed index i. `evt_dest` bit j equals `sub_mask[j*N_NODES+i]` for every j other than i, and `evt_dest` bit i is zero.
- R7: Events queued at the same time leave on consecutive cycles, lowest node index first.
- R8: A `fail_status` bit rises only at a sample edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| heartbeat | input | N_NODES*CNT_W | Heartbeat counts, node i in bits [i*CNT_W +: CNT_W] |
| miss_limit | input | MISS_W | Number of consecutive stale samples before failure |
| clear_fail | input | N_NODES | Per-node clear of the failed state |
| sub_mask | input | N_NODES*N_NODES | Row j (bits [j*N_NODES +: N_NODES]) selects which nodes' failures subscriber j receives |
| fail_status | output | N_NODES | Latched failed flags |
| evt_valid | output | 1 | One-cycle failure event strobe |
| evt_node | output | IDX_W | Index of the failed node |
| evt_dest | output | N_NODES | Subscribers that receive the event |

## Verification
Suppose a tracker's previous sample or miss count is corrupted. The result shows up on `fail_status` within at most `miss_limit` sample windows, either as a failure that comes too early or as one that is missing. Suppose instead the pending vector or the serializer state is wrong. Then `evt_valid`, `evt_node` or `evt_dest` differs on the very next cycle, or an event appears twice, is missing, or comes out of order. For this reason the outputs are compared with a model on every clock, not only at the end of a scenario.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
    typedef enum logic [0:0] {
        EV_QUIET = 1'b0,
        EV_SEND  = 1'b1
    } ev_state_e;
endpackage

// File: rtl/hbm_tick_gen.sv
module hbm_tick_gen #(
    parameter int INTERVAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/hbm_node_watch.sv
module hbm_node_watch #(
    parameter int CNT_W  = 16,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    input  logic [CNT_W-1:0]  beat,
    input  logic [MISS_W-1:0] limit,
    output logic              failed,
    output logic              declare
);
    logic [CNT_W-1:0]  last_q;
    logic [MISS_W-1:0] miss_q;
    logic              stale;
    logic [MISS_W:0]   miss_inc;

    assign stale    = (beat == last_q);
    assign miss_inc = {1'b0, miss_q} + 1'b1;
    // watching -> failed transition ("declare")
    assign declare  = tick && !failed && !clear && stale && (miss_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            miss_q <= '0;
            failed <= 1'b0;
        end else begin
            if (tick) last_q <= beat;
            if (clear) begin
                failed <= 1'b0;
                miss_q <= '0;
            end else if (tick && !failed) begin
                if (!stale) begin
                    miss_q <= '0;
                end else begin
                    miss_q <= miss_inc[MISS_W-1:0];
                    if (declare) failed <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hbm_event_fanout.sv
module hbm_event_fanout
    import hbm_pkg::*;
#(
    parameter int N_NODES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_NODES-1:0]         new_fail,
    input  logic [N_NODES-1:0]         clear,
    input  logic [N_NODES*N_NODES-1:0] sub_mask,
    output logic                       evt_valid,
    output logic [IDX_W-1:0]           evt_node,
    output logic [N_NODES-1:0]         evt_dest
);
    ev_state_e          state_q, state_d;
    logic [N_NODES-1:0] pending_q, live, grant, dest_c;
    logic [IDX_W-1:0]   pick;
    logic               found;

    assign live = pending_q & ~clear;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = N_NODES - 1; k >= 0; k--) begin
            if (live[k]) begin
                pick  = IDX_W'(k);
                found = 1'b1;
            end
        end
        grant = found ? (N_NODES'(1) << pick) : '0;
        for (int j = 0; j < N_NODES; j++) begin
            dest_c[j] = sub_mask[j*N_NODES + int'(pick)] && (j != int'(pick));
        end
    end

    // next state: grant / drain
    always_comb begin
        unique case (state_q)
            EV_QUIET: state_d = found ? EV_SEND : EV_QUIET;
            EV_SEND:  state_d = found ? EV_SEND : EV_QUIET;
            default:  state_d = EV_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= EV_QUIET;
            pending_q <= '0;
        end else begin
            state_q   <= state_d;
            pending_q <= (live & ~grant) | new_fail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_node <= '0;
            evt_dest <= '0;
        end else begin
            if (found) evt_node <= pick;
            evt_dest <= found ? dest_c : '0;
        end
    end

    assign evt_valid = (state_q == EV_SEND);
endmodule

// File: rtl/hb_failure_monitor.sv
module hb_failure_monitor #(
    parameter int N_NODES  = 8,
    parameter int CNT_W    = 16,
    parameter int MISS_W   = 4,
    parameter int INTERVAL = 64,
    localparam int IDX_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_NODES*CNT_W-1:0]   heartbeat,
    input  logic [MISS_W-1:0]          miss_limit,
    input  logic [N_NODES-1:0]         clear_fail,
    input  logic [N_NODES*N_NODES-1:0] sub_mask,
    output logic [N_NODES-1:0]         fail_status,
    output logic                       evt_valid,
    output logic [IDX_W-1:0]           evt_node,
    output logic [N_NODES-1:0]         evt_dest
);
    logic               tick;
    logic [N_NODES-1:0] declare;

    hbm_tick_gen #(.INTERVAL(INTERVAL)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar g = 0; g < N_NODES; g++) begin : g_node
        hbm_node_watch #(.CNT_W(CNT_W), .MISS_W(MISS_W)) watch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .clear  (clear_fail[g]),
            .beat   (heartbeat[g*CNT_W +: CNT_W]),
            .limit  (miss_limit),
            .failed (fail_status[g]),
            .declare(declare[g])
        );
    end

    hbm_event_fanout #(.N_NODES(N_NODES), .IDX_W(IDX_W)) fan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_fail (declare),
        .clear    (clear_fail),
        .sub_mask (sub_mask),
        .evt_valid(evt_valid),
        .evt_node (evt_node),
        .evt_dest (evt_dest)
    );
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker #(
    parameter int N_NODES = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [N_NODES-1:0] clear_fail,
    input logic [N_NODES-1:0] fail_status,
    input logic               evt_valid,
    input logic [IDX_W-1:0]   evt_node,
    input logic [N_NODES-1:0] evt_dest
);
    a_r4_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fail_status & ($past(fail_status) & ~$past(clear_fail)))
                  == ($past(fail_status) & ~$past(clear_fail))));

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fail_status & $past(clear_fail)) == '0));

    a_r8_rise_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((fail_status & ~$past(fail_status)) == '0));

    a_r6_event_names_failed: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> fail_status[evt_node]);

    a_r6_no_self_notify: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> !evt_dest[evt_node]);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (fail_status == '0 && !evt_valid));
endmodule

bind hb_failure_monitor hbm_checker #(.N_NODES(N_NODES), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clear_fail (clear_fail),
    .fail_status(fail_status),
    .evt_valid  (evt_valid),
    .evt_node   (evt_node),
    .evt_dest   (evt_dest)
);

// File: tb/hb_failure_monitor_tb.sv
`timescale 1ns/1ps
module hb_failure_monitor_tb_top;
    localparam int N   = 8;
    localparam int CW  = 16;
    localparam int MW  = 4;
    localparam int IV  = 16;
    localparam int IW  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N*CW-1:0]   heartbeat = '0;
    logic [MW-1:0]     miss_limit = 4'd3;
    logic [N-1:0]      clear_fail = '0;
    logic [N*N-1:0]    sub_mask = 64'hA5C3_0FF0_1234_FF7E;
    logic [N-1:0]      fail_status;
    logic              evt_valid;
    logic [IW-1:0]     evt_node;
    logic [N-1:0]      evt_dest;

    int vectors = 0;
    int errors  = 0;
    logic [N-1:0] running = '1;
    int seen[$];

    always #4 clk = ~clk;

    hb_failure_monitor #(.N_NODES(N), .CNT_W(CW), .MISS_W(MW), .INTERVAL(IV)) dut_i (
        .clk(clk), .rst_n(rst_n), .heartbeat(heartbeat), .miss_limit(miss_limit),
        .clear_fail(clear_fail), .sub_mask(sub_mask), .fail_status(fail_status),
        .evt_valid(evt_valid), .evt_node(evt_node), .evt_dest(evt_dest));

    // behavioural reference model
    int           m_pc;
    logic [CW-1:0] m_last[N];
    int           m_miss[N];
    logic [N-1:0] m_failed, m_pend;
    logic         m_valid;
    int           m_node;
    logic [N-1:0] m_dest;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_failed = '0; m_pend = '0; m_valid = 1'b0; m_node = 0; m_dest = '0;
            for (int i = 0; i < N; i++) begin m_last[i] = '0; m_miss[i] = 0; end
        end else begin
            bit tk;
            int lim;
            logic [N-1:0] eff, nf;
            tk   = (m_pc == IV - 1);
            m_pc = (m_pc + 1) % IV;
            lim  = (miss_limit == 0) ? 1 : int'(miss_limit);
            eff  = m_pend & ~clear_fail;
            m_valid = 1'b0;
            m_dest  = '0;
            for (int i = 0; i < N; i++) begin
                if (!m_valid && eff[i]) begin
                    m_valid = 1'b1; m_node = i; eff[i] = 1'b0;
                    for (int j = 0; j < N; j++)
                        m_dest[j] = (j != i) && sub_mask[j*N + i];
                end
            end
            nf = '0;
            for (int i = 0; i < N; i++) begin
                logic [CW-1:0] b;
                b = heartbeat[i*CW +: CW];
                if (clear_fail[i]) begin
                    m_failed[i] = 1'b0; m_miss[i] = 0;
                end else if (tk && !m_failed[i]) begin
                    if (b != m_last[i]) m_miss[i] = 0;
                    else begin
                        m_miss[i]++;
                        if (m_miss[i] >= lim) begin m_failed[i] = 1'b1; nf[i] = 1'b1; end
                    end
                end
                if (tk) m_last[i] = b;
            end
            m_pend = eff | nf;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check(fail_status == m_failed, "R2/R3/R4/R5/R8", "fail_status",
                  longint'(fail_status), longint'(m_failed));
            check(evt_valid == m_valid, "R6/R7", "evt_valid",
                  longint'(evt_valid), longint'(m_valid));
            if (m_valid) begin
                check(int'(evt_node) == m_node, "R6/R7", "evt_node",
                      longint'(evt_node), longint'(m_node));
                check(evt_dest == m_dest, "R6", "evt_dest",
                      longint'(evt_dest), longint'(m_dest));
            end
            if (evt_valid) seen.push_back(int'(evt_node));
            clear_fail = '0;
            for (int i = 0; i < N; i++)
                if (running[i]) heartbeat[i*CW +: CW] = heartbeat[i*CW +: CW] + 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) heartbeat[i*CW +: CW] = CW'(i * 100 + 1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fail_status == '0 && !evt_valid, "R1", "reset state",
              longint'({evt_valid, fail_status}), 0);
        cyc(100);
        check(fail_status == '0, "R2", "all progressing", longint'(fail_status), 0);

        running = 8'b1101_0110;            // nodes 0,3,5 stop
        cyc(80);
        check(fail_status == 8'b0010_1001, "R3", "three stalled", longint'(fail_status), 8'h29);
        check(seen.size() == 3, "R7", "event count", seen.size(), 3);
        if (seen.size() == 3)
            check(seen[0] == 0 && seen[1] == 3 && seen[2] == 5, "R7", "ascending order",
                  seen[0] * 256 + seen[1] * 16 + seen[2], 16'h035);
        cyc(80);
        check(seen.size() == 3, "R5", "no repeat report", seen.size(), 3);

        clear_fail = 8'b0000_1000;
        running[3] = 1'b1;
        cyc(60);
        check(fail_status[3] == 1'b0, "R4", "node 3 cleared", fail_status[3], 0);

        heartbeat[6*CW +: CW] = 16'hFFF8;    // wraps while running
        cyc(100);
        check(fail_status[6] == 1'b0, "R2", "wraparound progress", fail_status[6], 0);

        miss_limit = 4'd0;
        running[7] = 1'b0;
        cyc(40);
        check(fail_status[7] == 1'b1, "R3", "limit zero acts as one", fail_status[7], 1);

        miss_limit = 4'd15;
        running[1] = 1'b0;
        cyc(200);
        check(fail_status[1] == 1'b0, "R3", "limit 15 not yet", fail_status[1], 0);
        cyc(100);
        check(fail_status[1] == 1'b1, "R3", "limit 15 reached", fail_status[1], 1);

        clear_fail = 8'b0000_0001;           // node 0 still stalled: re-fails
        miss_limit = 4'd2;
        cyc(60);
        check(fail_status[0] == 1'b1, "R4", "re-declared after clear", fail_status[0], 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule